// File: doc/BRIEF.md
# GPIO Port Controller with Peripheral Pin Takeover

This block controls one 8-pin general-purpose I/O port. Software configures each pin through four writable registers: direction, output data, open-drain select and pull-up request. A fifth, read-only register returns the raw pad levels. From this configuration the block computes, per pin, the pad controls: output enable, output value, pull-up enable and pull-down enable. The pad cells, the serial peripherals and any input filtering live outside.

Two peripherals can claim pins regardless of the registers. A synchronous serial unit takes two pins as open-drain lines, and a UART takes one pin as its transmit output and another as its receive input. The pull-up is only switched on when the pin is not actively driving, which saves power. One pin is pulled down instead of up while power-on reset is held. Register reads are combinational, and the pad controls follow configuration and peripheral inputs in the same cycle.

Top module: `gpio_port`

## Requirements
- R1: After the synchronous configuration reset `rst`, direction, output data and open-drain registers read 0x00 and the pull-up register reads 0xFF.
- R2: Register addresses: 0 direction, 1 output data, 2 open-drain select, 3 pull-up request, 4 pad input (read-only). A write with `wr_en` high is stored at the next rising clock edge. `rd_data` shows the addressed register combinationally. Unmapped addresses read 0x00.
- R3: Address 4 returns `pad_in` directly, also for pins configured as outputs. Writes to address 4 change no register.
- R4: A pin whose effective direction is 0 has `pad_oe` low. A push-pull pin with direction 1 has `pad_oe` high and `pad_out` equal to its output data bit.
- R5: An open-drain output with data 0 drives low (`pad_oe` high, `pad_out` low). With data 1 it is released (`pad_oe` low).
- R6: `pad_pu[i]` is high only when the pin's pull-up request bit is 1 and the pin is released (`pad_oe` low). A driving pin never has its pull-up on.
- R7: While `por_active` is high, pin 1 has `pad_pd` high and `pad_pu` low. `pad_pd` is low for every other pin, and for pin 1 when `por_active` is low.
- R8: With `ser_en` high, pins 4 and 5 are open-drain outputs whatever their direction, data and open-drain bits say. If the line is marked as output (`ser_s0_is_out` / `ser_s1_is_out`), the pin carries `ser_s0_val` / `ser_s1_val`. Otherwise it is released.
- R9: With `uart_tx_en` high, pin 6 is an output carrying `uart_tx`, overriding its direction and data bits. Its open-drain bit still applies.
- R10: With `uart_rx_en` high, pin 7 is forced to input and `uart_rx` equals `pad_in[7]`. With it low, `uart_rx` is 1 (idle).
- R11: `pad_out` is 0 on every pin whose `pad_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous configuration reset, active high |
| por_active | input | 1 | Power-on reset in progress |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational) |
| ser_en | input | 1 | Serial unit claims pins 4 and 5 |
| ser_s0_is_out | input | 1 | Serial line 0 is driven |
| ser_s1_is_out | input | 1 | Serial line 1 is driven |
| ser_s0_val | input | 1 | Serial line 0 value |
| ser_s1_val | input | 1 | Serial line 1 value |
| uart_tx_en | input | 1 | UART claims pin 6 for transmit |
| uart_tx | input | 1 | UART transmit data |
| uart_rx_en | input | 1 | UART claims pin 7 for receive |
| uart_rx | output | 1 | UART receive data from pin 7 |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_pu | output | 8 | Pad pull-up enable |
| pad_pd | output | 8 | Pad pull-down enable |

## Verification
The bench builds the block with its default parameters: eight pins, pull-down on pin 1, serial lines on pins 4 and 5, UART on pins 6 and 7. This puts every takeover pin and the power-on pull-down pin inside one byte, so a single vector can mix all overrides with register-driven pins. The vectors cover push-pull, open-drain, power-on pull-down, serial and UART takeovers, and combinations of them. Each vector's expected pad controls come from a bench model written from the requirements.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_DIR = 3'd0,
        SEL_DAT = 3'd1,
        SEL_ODM = 3'd2,
        SEL_PUP = 3'd3,
        SEL_PIN = 3'd4
    } reg_sel_e;

    // effective configuration of one pin after peripheral overrides
    typedef struct packed {
        logic dir;
        logic dat;
        logic odm;
        logic pup;
    } pin_cfg_t;

    // pad control bundle of one pin
    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
        logic pd;
    } pad_ctl_t;

    function automatic pad_ctl_t resolve_pad(input pin_cfg_t c, input logic force_pd);
        pad_ctl_t r;
        logic released;
        released = !c.dir || (c.odm && c.dat);
        r.oe  = !released;
        r.out = !released && c.dat;
        r.pu  = c.pup && released && !force_pd;
        r.pd  = force_pd;
        return r;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]      wr_data,
    input  logic [NPINS-1:0]      pad_in,
    output logic [NPINS-1:0]      dir_q,
    output logic [NPINS-1:0]      dat_q,
    output logic [NPINS-1:0]      odm_q,
    output logic [NPINS-1:0]      pup_q,
    output logic [NPINS-1:0]      rd_data
);

    localparam logic [NPINS-1:0] ALL_ZERO = '0;
    localparam logic [NPINS-1:0] ALL_ONE  = '1;

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= ALL_ZERO;
            dat_q <= ALL_ZERO;
            odm_q <= ALL_ZERO;
            pup_q <= ALL_ONE;
        end else if (wr_en) begin
            case (sel)
                SEL_DIR: dir_q <= wr_data;
                SEL_DAT: dat_q <= wr_data;
                SEL_ODM: odm_q <= wr_data;
                SEL_PUP: pup_q <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_DIR: rd_data = dir_q;
            SEL_DAT: rd_data = dat_q;
            SEL_ODM: rd_data = odm_q;
            SEL_PUP: rd_data = pup_q;
            SEL_PIN: rd_data = pad_in;
            default: rd_data = ALL_ZERO;
        endcase
    end

endmodule

// File: rtl/gpio_altfunc.sv
module gpio_altfunc
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int S0_PIN = 4,
    parameter int S1_PIN = 5,
    parameter int TX_PIN = 6,
    parameter int RX_PIN = 7
) (
    input  logic [NPINS-1:0]     dir_q,
    input  logic [NPINS-1:0]     dat_q,
    input  logic [NPINS-1:0]     odm_q,
    input  logic [NPINS-1:0]     pup_q,
    input  logic                 ser_en,
    input  logic                 ser_s0_is_out,
    input  logic                 ser_s1_is_out,
    input  logic                 ser_s0_val,
    input  logic                 ser_s1_val,
    input  logic                 uart_tx_en,
    input  logic                 uart_tx,
    input  logic                 uart_rx_en,
    input  logic                 rx_pad,
    output pin_cfg_t [NPINS-1:0] cfg,
    output logic                 uart_rx
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_cfg_t base;
        assign base = '{dir: dir_q[i], dat: dat_q[i], odm: odm_q[i], pup: pup_q[i]};

        if (i == S0_PIN) begin : g_s0
            always_comb begin
                cfg[i] = base;
                if (ser_en) begin
                    cfg[i].dir = 1'b1;
                    cfg[i].odm = 1'b1;
                    cfg[i].dat = ser_s0_is_out ? ser_s0_val : 1'b1;
                end
            end
        end else if (i == S1_PIN) begin : g_s1
            always_comb begin
                cfg[i] = base;
                if (ser_en) begin
                    cfg[i].dir = 1'b1;
                    cfg[i].odm = 1'b1;
                    cfg[i].dat = ser_s1_is_out ? ser_s1_val : 1'b1;
                end
            end
        end else if (i == TX_PIN) begin : g_tx
            always_comb begin
                cfg[i] = base;
                if (uart_tx_en) begin
                    cfg[i].dir = 1'b1;
                    cfg[i].dat = uart_tx;
                end
            end
        end else if (i == RX_PIN) begin : g_rx
            always_comb begin
                cfg[i] = base;
                if (uart_rx_en) begin
                    cfg[i].dir = 1'b0;
                end
            end
        end else begin : g_gp
            assign cfg[i] = base;
        end
    end

    assign uart_rx = uart_rx_en ? rx_pad : 1'b1;

endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int PD_PIN = 1
) (
    input  pin_cfg_t [NPINS-1:0] cfg,
    input  logic                 por_active,
    output logic [NPINS-1:0]     pad_oe,
    output logic [NPINS-1:0]     pad_out,
    output logic [NPINS-1:0]     pad_pu,
    output logic [NPINS-1:0]     pad_pd
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pad
        pad_ctl_t ctl;
        logic     force_pd;

        if (i == PD_PIN) begin : g_pd
            assign force_pd = por_active;
        end else begin : g_nopd
            assign force_pd = 1'b0;
        end

        assign ctl        = resolve_pad(cfg[i], force_pd);
        assign pad_oe[i]  = ctl.oe;
        assign pad_out[i] = ctl.out;
        assign pad_pu[i]  = ctl.pu;
        assign pad_pd[i]  = ctl.pd;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int PD_PIN = 1,
    parameter int S0_PIN = 4,
    parameter int S1_PIN = 5,
    parameter int TX_PIN = 6,
    parameter int RX_PIN = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por_active,
    input  logic [2:0]       addr,
    input  logic             wr_en,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] rd_data,
    input  logic             ser_en,
    input  logic             ser_s0_is_out,
    input  logic             ser_s1_is_out,
    input  logic             ser_s0_val,
    input  logic             ser_s1_val,
    input  logic             uart_tx_en,
    input  logic             uart_tx,
    input  logic             uart_rx_en,
    output logic             uart_rx,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_pu,
    output logic [NPINS-1:0] pad_pd
);

    logic [NPINS-1:0]     dir_q, dat_q, odm_q, pup_q;
    pin_cfg_t [NPINS-1:0] cfg;

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .pad_in  (pad_in),
        .dir_q   (dir_q),
        .dat_q   (dat_q),
        .odm_q   (odm_q),
        .pup_q   (pup_q),
        .rd_data (rd_data)
    );

    gpio_altfunc #(
        .NPINS (NPINS),
        .S0_PIN(S0_PIN),
        .S1_PIN(S1_PIN),
        .TX_PIN(TX_PIN),
        .RX_PIN(RX_PIN)
    ) u_alt (
        .dir_q         (dir_q),
        .dat_q         (dat_q),
        .odm_q         (odm_q),
        .pup_q         (pup_q),
        .ser_en        (ser_en),
        .ser_s0_is_out (ser_s0_is_out),
        .ser_s1_is_out (ser_s1_is_out),
        .ser_s0_val    (ser_s0_val),
        .ser_s1_val    (ser_s1_val),
        .uart_tx_en    (uart_tx_en),
        .uart_tx       (uart_tx),
        .uart_rx_en    (uart_rx_en),
        .rx_pad        (pad_in[RX_PIN]),
        .cfg           (cfg),
        .uart_rx       (uart_rx)
    );

    gpio_padctl #(.NPINS(NPINS), .PD_PIN(PD_PIN)) u_pad (
        .cfg        (cfg),
        .por_active (por_active),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_pu     (pad_pu),
        .pad_pd     (pad_pd)
    );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int NPINS  = 8,
    parameter int PD_PIN = 1,
    parameter int S0_PIN = 4,
    parameter int TX_PIN = 6,
    parameter int RX_PIN = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             por_active,
    input logic             ser_en,
    input logic             ser_s0_is_out,
    input logic             uart_tx_en,
    input logic             uart_tx,
    input logic             uart_rx_en,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_pu,
    input logic [NPINS-1:0] pad_pd
);

    localparam logic [NPINS-1:0] PD_MASK = NPINS'(1) << PD_PIN;

    // R6
    pu_never_on_driver_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_oe) == '0);

    // R7
    por_blocks_pullup_chk: assert property (@(posedge clk) disable iff (rst)
        por_active |-> (pad_pd[PD_PIN] && !pad_pu[PD_PIN]));

    // R7
    pulldown_only_on_por_pin_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_pd & ~PD_MASK) == '0) && (pad_pd[PD_PIN] -> por_active));

    // R8
    serial_input_released_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_en && !ser_s0_is_out) |-> !pad_oe[S0_PIN]);

    // R9
    uart_tx_low_driven_chk: assert property (@(posedge clk) disable iff (rst)
        (uart_tx_en && !uart_tx) |-> (pad_oe[TX_PIN] && !pad_out[TX_PIN]));

    // R10
    uart_rx_is_input_chk: assert property (@(posedge clk) disable iff (rst)
        uart_rx_en |-> !pad_oe[RX_PIN]);

    // R11
    no_value_when_released_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0);

endmodule

bind gpio_port gpio_port_chk #(
    .NPINS (NPINS),
    .PD_PIN(PD_PIN),
    .S0_PIN(S0_PIN),
    .TX_PIN(TX_PIN),
    .RX_PIN(RX_PIN)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .por_active    (por_active),
    .ser_en        (ser_en),
    .ser_s0_is_out (ser_s0_is_out),
    .uart_tx_en    (uart_tx_en),
    .uart_tx       (uart_tx),
    .uart_rx_en    (uart_rx_en),
    .pad_oe        (pad_oe),
    .pad_out       (pad_out),
    .pad_pu        (pad_pu),
    .pad_pd        (pad_pd)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] dat;
        logic [7:0] odm;
        logic [7:0] pup;
        logic [7:0] pin;
        logic       ser;
        logic       s0o;
        logic       s1o;
        logic       s0v;
        logic       s1v;
        logic       txe;
        logic       tx;
        logic       rxe;
        logic       por;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'hFF, 8'hAA, 8'h00, 8'hFF, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0},
        '{8'hFF, 8'h0F, 8'hFF, 8'hFF, 8'h3C, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0},
        '{8'h00, 8'hFF, 8'hFF, 8'h0F, 8'h5A, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0},
        '{8'h0F, 8'hF0, 8'h33, 8'hFF, 8'hC3, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b1},
        '{8'h00, 8'h00, 8'h00, 8'hFF, 8'h11, 1'b1,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b0,1'b0, 1'b0},
        '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'h22, 1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b0},
        '{8'h00, 8'h00, 8'h00, 8'hFF, 8'h80, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 1'b0},
        '{8'hFF, 8'h00, 8'h40, 8'hFF, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1, 1'b0},
        '{8'hC3, 8'h5A, 8'hA5, 8'h3C, 8'h7E, 1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1, 1'b1},
        '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 1'b1,1'b0,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por_active = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ser_en = 1'b0, ser_s0_is_out = 1'b0, ser_s1_is_out = 1'b0;
    logic       ser_s0_val = 1'b0, ser_s1_val = 1'b0;
    logic       uart_tx_en = 1'b0, uart_tx = 1'b0, uart_rx_en = 1'b0;
    logic       uart_rx;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_pu, pad_pd;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port uut (
        .clk(clk), .rst(rst), .por_active(por_active),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ser_en(ser_en), .ser_s0_is_out(ser_s0_is_out), .ser_s1_is_out(ser_s1_is_out),
        .ser_s0_val(ser_s0_val), .ser_s1_val(ser_s1_val),
        .uart_tx_en(uart_tx_en), .uart_tx(uart_tx), .uart_rx_en(uart_rx_en),
        .uart_rx(uart_rx), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    // Reference model written from R4..R10
    task automatic model(input vec_t v, output logic [7:0] e_oe, output logic [7:0] e_out,
                         output logic [7:0] e_pu, output logic [7:0] e_pd, output logic e_rx);
        for (int i = 0; i < 8; i++) begin
            logic d, o, od, drv;
            d = v.dir[i]; o = v.dat[i]; od = v.odm[i];
            if (v.ser && i == 4) begin d = 1'b1; od = 1'b1; o = v.s0o ? v.s0v : 1'b1; end
            if (v.ser && i == 5) begin d = 1'b1; od = 1'b1; o = v.s1o ? v.s1v : 1'b1; end
            if (v.txe && i == 6) begin d = 1'b1; o = v.tx; end
            if (v.rxe && i == 7) d = 1'b0;
            if (!d)            drv = 1'b0;
            else if (od && o)  drv = 1'b0;
            else               drv = 1'b1;
            e_oe[i]  = drv;
            e_out[i] = drv ? o : 1'b0;
            e_pu[i]  = v.pup[i] && !drv;
            e_pd[i]  = 1'b0;
            if (i == 1 && v.por) begin e_pu[i] = 1'b0; e_pd[i] = 1'b1; end
        end
        e_rx = v.rxe ? v.pin[7] : 1'b1;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] e_oe, e_out, e_pu, e_pd;
        logic e_rx;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 defaults
        read_check("R1 dir reset", 3'd0, 8'h00);
        read_check("R1 dat reset", 3'd1, 8'h00);
        read_check("R1 odm reset", 3'd2, 8'h00);
        read_check("R1 pup reset", 3'd3, 8'hFF);
        check("R4 reset all inputs", pad_oe, 8'h00);
        check("R6 reset pull-ups", pad_pu, 8'hFF);
        check("R10 rx idle", {7'd0, uart_rx}, 8'h01);

        // R7 power-on pull-down on pin 1
        por_active = 1'b1; #1;
        check("R7 por pd", pad_pd, 8'h02);
        check("R7 por pu", pad_pu, 8'hFD);
        por_active = 1'b0; #1;
        check("R7 after por pd", pad_pd, 8'h00);
        check("R7 after por pu", pad_pu, 8'hFF);

        // R2 unmapped address and R3 input register write ignored
        read_check("R2 unmapped", 3'd6, 8'h00);
        pad_in = 8'hA3;
        write_reg(3'd4, 8'h55);
        read_check("R3 pin read", 3'd4, 8'hA3);
        read_check("R3 no side write dir", 3'd0, 8'h00);
        read_check("R3 no side write dat", 3'd1, 8'h00);
        read_check("R3 no side write odm", 3'd2, 8'h00);
        read_check("R3 no side write pup", 3'd3, 8'hFF);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            write_reg(3'd0, VECS[k].dir);
            write_reg(3'd1, VECS[k].dat);
            write_reg(3'd2, VECS[k].odm);
            write_reg(3'd3, VECS[k].pup);
            pad_in = VECS[k].pin;
            ser_en = VECS[k].ser; ser_s0_is_out = VECS[k].s0o; ser_s1_is_out = VECS[k].s1o;
            ser_s0_val = VECS[k].s0v; ser_s1_val = VECS[k].s1v;
            uart_tx_en = VECS[k].txe; uart_tx = VECS[k].tx; uart_rx_en = VECS[k].rxe;
            por_active = VECS[k].por;
            #1;
            model(VECS[k], e_oe, e_out, e_pu, e_pd, e_rx);
            check("R4 R5 R8 R9 R10 oe", pad_oe, e_oe);
            check("R4 R5 R8 R9 R11 out", pad_out, e_out);
            check("R6 R7 pu", pad_pu, e_pu);
            check("R7 pd", pad_pd, e_pd);
            check("R10 uart_rx", {7'd0, uart_rx}, {7'd0, e_rx});
            read_check("R2 R3 pin readback", 3'd4, VECS[k].pin);
            read_check("R2 dir readback", 3'd0, VECS[k].dir);
        end

        // R8 register bits of serial pins ignored: release both lines
        por_active = 1'b0; uart_tx_en = 1'b0; uart_rx_en = 1'b0;
        write_reg(3'd0, 8'hFF); write_reg(3'd1, 8'h00); write_reg(3'd2, 8'h00);
        write_reg(3'd3, 8'hFF);
        ser_en = 1'b1; ser_s0_is_out = 1'b0; ser_s1_is_out = 1'b0;
        #1;
        check("R8 serial released oe", pad_oe, 8'hCF);
        check("R6 R8 released pullup", pad_pu, 8'h30);

        // R1 configuration reset mid-run
        ser_en = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_check("R1 dir after rst", 3'd0, 8'h00);
        read_check("R1 pup after rst", 3'd3, 8'hFF);
        check("R1 pads after rst", pad_oe, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule